// File: doc/BRIEF.md
# Operand-Inverting Arithmetic Logic Unit

A purely combinational arithmetic-logic unit of configurable width (32 bits by default). A 4-bit operation code drives two operand controls and a result selector. Bit 3 inverts operand A. Bit 2 inverts operand B and also supplies the adder carry-in, which turns the adder into a two's-complement subtractor. Bits 1:0 select the result source: the bitwise AND of the conditioned operands, their bitwise OR, the adder sum, or the signed less-than value.

NOR is produced by inverting both operands and selecting the AND path. Subtraction and set-less-than share the negate-B path. A zero-detect output on the result supports branch-if-equal: the caller subtracts and tests the flag. The adder is a carry-lookahead design built from 4-bit groups. Each group forms a group generate and a group propagate, and the group carries chain from one group to the next.

Top module: `opctl_alu`

## Requirements
- R1: Code 4'b0000 drives `result` to `opnd_a & opnd_b`.
- R2: Code 4'b0001 drives `result` to `opnd_a | opnd_b`.
- R3: Code 4'b0010 drives `result` to `(opnd_a + opnd_b) mod 2^WIDTH` and `carry_out` to the unsigned carry out of the MSB.
- R4: Code 4'b0110 drives `result` to `(opnd_a - opnd_b) mod 2^WIDTH` and `carry_out` to 1 exactly when `opnd_a >= opnd_b` unsigned (no borrow).
- R5: Code 4'b0111 drives `result` bit 0 to 1 exactly when `opnd_a < opnd_b` as signed two's-complement values, and clears all higher bits. The result is correct even when the internal subtraction overflows.
- R6: Code 4'b1100 drives `result` to `~(opnd_a | opnd_b)`.
- R7: `is_zero` is 1 exactly when every bit of `result` is 0, for every code.
- R8: `ovf` is 1 for codes 4'b0010 and 4'b0110 exactly when the signed sum or difference does not fit in WIDTH bits. It is 0 for every other code.
- R9: `carry_out` is 0 for every code other than 4'b0010 and 4'b0110.
- R10: Any code other than the six above gives `result` = 0, and therefore `is_zero` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| op_code | input | 4 | {invert A, negate B, source select[1:0]} |
| result | output | WIDTH | Selected result |
| is_zero | output | 1 | Result is all zeros |
| carry_out | output | 1 | Adder carry out of MSB (add/subtract only) |
| ovf | output | 1 | Signed overflow (add/subtract only) |

## Verification
The bound checker tests every input change for the relations that can be stated from the ports alone. These are: the zero flag agrees with the result; set-less-than leaves the upper bits clear; the flags stay low outside add and subtract; undefined codes give a zero result; and the AND and NOR results match the bitwise functions of the operands. The arithmetic values themselves are shown only by the bench. It runs an 8-bit instance over every operand pair under all sixteen codes and compares each output against sums, differences and signed comparisons computed as integers. That sweep covers carries that run across group boundaries, signed overflow at both extremes, and set-less-than across the overflow cases.

// File: rtl/opctl_alu_pkg.sv
package opctl_alu_pkg;
  localparam logic [3:0] OPC_AND = 4'b0000;
  localparam logic [3:0] OPC_OR  = 4'b0001;
  localparam logic [3:0] OPC_ADD = 4'b0010;
  localparam logic [3:0] OPC_SUB = 4'b0110;
  localparam logic [3:0] OPC_SLT = 4'b0111;
  localparam logic [3:0] OPC_NOR = 4'b1100;

  typedef enum logic [1:0] {
    SRC_AND = 2'b00,
    SRC_OR  = 2'b01,
    SRC_SUM = 2'b10,
    SRC_LT  = 2'b11
  } res_src_e;

  function automatic logic opc_legal(input logic [3:0] c);
    return (c == OPC_AND) || (c == OPC_OR) || (c == OPC_ADD) ||
           (c == OPC_SUB) || (c == OPC_SLT) || (c == OPC_NOR);
  endfunction
endpackage

// File: rtl/opctl_cla_adder.sv
module opctl_cla_adder #(
  parameter int WIDTH = 32,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             c_into_msb,
  output logic             c_out
);
  localparam int NGRP = WIDTH / GROUP;

  logic [WIDTH-1:0] gen;
  logic [WIDTH-1:0] prop;
  logic [WIDTH:0]   cy;

  assign gen  = x & y;
  assign prop = x | y;
  assign cy[0] = cin;

  for (genvar k = 0; k < NGRP; k++) begin : g_grp
    localparam int BASE = k * GROUP;
    logic [GROUP:0] gacc;
    logic [GROUP:0] pacc;
    assign gacc[0] = 1'b0;
    assign pacc[0] = 1'b1;
    for (genvar j = 0; j < GROUP; j++) begin : g_bit
      assign gacc[j+1] = gen[BASE+j] | (prop[BASE+j] & gacc[j]);
      assign pacc[j+1] = prop[BASE+j] & pacc[j];
      if (j < GROUP - 1) begin : g_inner
        assign cy[BASE+j+1] = gen[BASE+j] | (prop[BASE+j] & cy[BASE+j]);
      end
    end
    // group carry uses only group generate/propagate and the incoming carry
    assign cy[BASE+GROUP] = gacc[GROUP] | (pacc[GROUP] & cy[BASE]);
  end

  assign sum        = x ^ y ^ cy[WIDTH-1:0];
  assign c_into_msb = cy[WIDTH-1];
  assign c_out      = cy[WIDTH];
endmodule

// File: rtl/opctl_zero_detect.sv
module opctl_zero_detect #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] value,
  output logic             all_zero
);
  assign all_zero = ~|value;
endmodule

// File: rtl/opctl_alu.sv
module opctl_alu
  import opctl_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [3:0]       op_code,
  output logic [WIDTH-1:0] result,
  output logic             is_zero,
  output logic             carry_out,
  output logic             ovf
);
  logic             inv_a;
  logic             neg_b;
  res_src_e         src;
  logic [WIDTH-1:0] a_c;
  logic [WIDTH-1:0] b_c;
  logic [WIDTH-1:0] sum;
  logic             c_msb;
  logic             c_top;
  logic             sgn_ovf;
  logic             less;
  logic             legal;
  logic             arith;

  assign inv_a = op_code[3];
  assign neg_b = op_code[2];
  assign src   = res_src_e'(op_code[1:0]);
  assign legal = opc_legal(op_code);
  assign arith = (op_code == OPC_ADD) || (op_code == OPC_SUB);

  assign a_c = opnd_a ^ {WIDTH{inv_a}};
  assign b_c = opnd_b ^ {WIDTH{neg_b}};

  opctl_cla_adder #(.WIDTH(WIDTH), .GROUP(GROUP)) u_add (
    .x(a_c), .y(b_c), .cin(neg_b),
    .sum(sum), .c_into_msb(c_msb), .c_out(c_top)
  );

  assign sgn_ovf = c_msb ^ c_top;
  assign less    = sum[WIDTH-1] ^ sgn_ovf;

  always_comb begin
    result = '0;
    if (legal) begin
      unique case (src)
        SRC_AND: result = a_c & b_c;
        SRC_OR:  result = a_c | b_c;
        SRC_SUM: result = sum;
        SRC_LT:  result = {{(WIDTH-1){1'b0}}, less};
        default: result = '0;
      endcase
    end
  end

  assign carry_out = arith & c_top;
  assign ovf       = arith & sgn_ovf;

  opctl_zero_detect #(.WIDTH(WIDTH)) u_zd (.value(result), .all_zero(is_zero));
endmodule

// File: rtl/opctl_alu_chk.sv
module opctl_alu_chk
  import opctl_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [3:0]       op_code,
  input logic [WIDTH-1:0] result,
  input logic             is_zero,
  input logic             carry_out,
  input logic             ovf
);
  always_comb begin
    a_r7_zero_flag: assert (is_zero == (result == '0));
    if (op_code == OPC_AND) begin
      a_r1_and_value: assert (result == (opnd_a & opnd_b));
    end
    if (op_code == OPC_NOR) begin
      a_r6_nor_value: assert (result == ~(opnd_a | opnd_b));
    end
    if (op_code == OPC_SLT) begin
      a_r5_slt_upper_clear: assert (result[WIDTH-1:1] == '0);
    end
    if (op_code != OPC_ADD && op_code != OPC_SUB) begin
      a_r8_no_overflow: assert (!ovf);
      a_r9_no_carry: assert (!carry_out);
    end
    if (!opc_legal(op_code)) begin
      a_r10_undefined_zero: assert (result == '0);
    end
  end
endmodule

bind opctl_alu opctl_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .opnd_a(opnd_a), .opnd_b(opnd_b), .op_code(op_code), .result(result),
  .is_zero(is_zero), .carry_out(carry_out), .ovf(ovf)
);

// File: tb/opctl_alu_bench.sv
module opctl_alu_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int W = 8;
  localparam int M = 1 << W;

  logic         clk = 1'b0;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic [3:0]   op_code = '0;
  logic [W-1:0] result;
  logic         is_zero;
  logic         carry_out;
  logic         ovf;
  int           n_chk = 0;
  int           n_fail = 0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  opctl_alu #(.WIDTH(W), .GROUP(4)) u_opctl_alu (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .op_code(op_code),
    .result(result), .is_zero(is_zero), .carry_out(carry_out), .ovf(ovf)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: code=%b a=%h b=%h actual=%h expected=%h",
               req, what, op_code, opnd_a, opnd_b, act, exp);
    end
  endtask

  task automatic check_one(input int ia, input int ib, input int code);
    int    sa, sb, res, cy, ov, s;
    string rq;
    sa = (ia >= M/2) ? ia - M : ia;
    sb = (ib >= M/2) ? ib - M : ib;
    cy = 0; ov = 0; res = 0; rq = "R10";
    case (code)
      0:  begin res = ia & ib; rq = "R1"; end
      1:  begin res = ia | ib; rq = "R2"; end
      2:  begin res = (ia + ib) % M; cy = (ia + ib >= M) ? 1 : 0;
                s = sa + sb; ov = (s > M/2-1 || s < -M/2) ? 1 : 0; rq = "R3"; end
      6:  begin res = (ia - ib + M) % M; cy = (ia >= ib) ? 1 : 0;
                s = sa - sb; ov = (s > M/2-1 || s < -M/2) ? 1 : 0; rq = "R4"; end
      7:  begin res = (sa < sb) ? 1 : 0; rq = "R5"; end
      12: begin res = (~(ia | ib)) & (M-1); rq = "R6"; end
      default: begin res = 0; rq = "R10"; end
    endcase
    chk(rq, "result", int'(result), res);
    chk("R7", "is_zero", int'(is_zero), (res == 0) ? 1 : 0);
    chk((code == 2 || code == 6) ? rq : "R9", "carry_out", int'(carry_out), cy);
    chk("R8", "ovf", int'(ovf), ov);
  endtask

  initial begin
    for (int ia = 0; ia < M; ia++) begin
      for (int ib = 0; ib < M; ib++) begin
        @(posedge clk);
        #1;
        opnd_a = W'(ia);
        opnd_b = W'(ib);
        for (int code = 0; code < 16; code++) begin
          op_code = 4'(code);
          #0.5;
          check_one(ia, ib, code);
        end
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (M * M + 2000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule